// File: doc/BRIEF.md
# Iterative Shift-Add Multiplier

This block multiplies two unsigned operands of `WIDTH` bits each and returns the full product of `2*WIDTH` bits. It handles one multiplier bit per clock, so a result takes `WIDTH` clock cycles after the operands are captured. The only storage is one register for the multiplicand and one double-width register. The low half of the double-width register starts out holding the multiplier and the high half holds the partial sum. Each cycle one multiplier bit is used up at the bottom of the register, and one product bit arrives from the top.

A request is a one-cycle `start_i` pulse with both operands present. It is accepted only while the block is idle. `busy_o` stays high for as long as the iterations run. `done_o` pulses for one cycle when the full product is on `product_o`. The product stays on the output until the next accepted request.

Top module: `shift_add_mult`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block becomes idle: `busy_o` is 0, `done_o` is 0 and `product_o` is all zeros.
- R2: A `start_i` pulse while `busy_o` is 0 captures both operands at that edge. After that edge, `busy_o` is 1, the upper `WIDTH` bits of `product_o` are zero and the lower `WIDTH` bits equal the multiplier.
- R3: Each busy cycle tests bit 0 of the double-width register. If the bit is 1, the multiplicand is added to the upper half through a `WIDTH+1`-bit adder; if it is 0, zero is added. The result, with the adder's carry as the new bit `2*WIDTH-1`, is then shifted right by one.
- R4: Exactly `WIDTH` iterations run, one per clock. `busy_o` falls and `done_o` rises at the `WIDTH`-th edge after the capturing edge.
- R5: `done_o` is high for exactly one cycle per accepted request.
- R6: When `done_o` is high, `product_o` equals the unsigned product of the captured operands, including the all-ones by all-ones case and the cases with a zero operand.
- R7: A `start_i` pulse while `busy_o` is 1 is ignored. The running computation and its final product do not change.
- R8: After `done_o`, `product_o` holds its value until the next accepted start. A start in the same cycle that `done_o` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request pulse |
| mcand_i | input | WIDTH | Multiplicand operand |
| mplier_i | input | WIDTH | Multiplier operand |
| busy_o | output | 1 | High while iterations run |
| done_o | output | 1 | One-cycle pulse: product valid |
| product_o | output | 2*WIDTH | Double-width product register |

## Verification
The bench builds the block with `WIDTH = 6`. At that width every one of the 4096 operand pairs can be run, so every carry out of the widened adder and every pattern of multiplier bits is covered, and each result is compared with the arithmetic product. At this width the latency check is six cycles, and the first iteration can be observed step by step. Ignored starts, a start in the done cycle and the hold of the result are run at the same width.

// File: rtl/shift_add_pkg.sv
// Package: shared types for the shift-add multiplier.
// Assumes: nothing beyond the SystemVerilog standard.
package shift_add_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/shift_add_seq.sv
// Module: sequencer for the iterative multiplier. It accepts a start
// while idle, counts WIDTH iteration cycles and pulses done after the
// last one.
// Assumes: start is sampled only while idle; WIDTH >= 2.
module shift_add_seq
    import shift_add_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             last_step;

    assign load_o    = start_i && (state_q == SEQ_IDLE);
    assign step_o    = (state_q == SEQ_RUN);
    assign last_step = step_o && (cnt_q == LAST_CNT);
    assign busy_o    = step_o;
    assign done_o    = done_q;

    // Purpose: move between idle and running, and count the iterations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else if (load_o) begin
            state_q <= SEQ_RUN;
            cnt_q   <= '0;
        end else if (last_step) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else if (step_o) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Purpose: raise done for the single cycle after the last iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= last_step;
    end

    // R4
    // iter_count_chk: the counter never reaches WIDTH.
    iter_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);

    // R4
    // busy_to_done_chk: the end of a run always brings done.
    busy_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R5
    // done_single_chk: done never lasts two cycles.
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    // start_ignored_chk: a start while running does not restart the count.
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !last_step) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/shift_add_dp.sv
// Module: datapath of the iterative multiplier. It holds the
// multiplicand register and one double-width register whose low half
// starts as the multiplier and whose high half builds up the sum.
// Assumes: load and step are never both high.
module shift_add_dp #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               step_i,
    input  logic [WIDTH-1:0]   mcand_i,
    input  logic [WIDTH-1:0]   mplier_i,
    output logic [2*WIDTH-1:0] acc_o
);
    localparam int ACC_W = 2 * WIDTH;

    logic [WIDTH-1:0] mcand_q;
    logic [ACC_W-1:0] acc_q;
    logic [WIDTH:0]   addend;
    logic [WIDTH:0]   sum;
    logic [ACC_W-1:0] acc_next;

    // Purpose: select the multiplicand or zero from bit 0, add it to the
    // high half, and form the right-shifted register value.
    always_comb begin
        addend   = acc_q[0] ? {1'b0, mcand_q} : '0;
        sum      = {1'b0, acc_q[ACC_W-1:WIDTH]} + addend;
        acc_next = {sum, acc_q[WIDTH-1:1]};
    end

    // Purpose: capture the operands on load and hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      mcand_q <= '0;
        else if (load_i) mcand_q <= mcand_i;
    end

    // Purpose: clear the high half on load, then add and shift each step.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (load_i) acc_q <= {{WIDTH{1'b0}}, mplier_i};
        else if (step_i) acc_q <= acc_next;
    end

    assign acc_o = acc_q;

    // R2
    // load_value_chk: after a load the high half is clear and the low half holds the multiplier.
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (acc_q[ACC_W-1:WIDTH] == '0 && acc_q[WIDTH-1:0] == $past(mplier_i)));

    // R3
    // zero_bit_shift_chk: a clear test bit only shifts the register.
    zero_bit_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !acc_q[0]) |=> (acc_q == ($past(acc_q) >> 1)));

    // R7
    // mcand_hold_chk: the multiplicand does not change while iterating.
    mcand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> $stable(mcand_q));

    // R8
    // idle_hold_chk: with no accepted start the register keeps its value.
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(acc_q));
endmodule

// File: rtl/shift_add_mult.sv
// Module: top of the iterative unsigned multiplier. It joins the
// sequencer and the datapath; the product register drives the output
// directly.
// Assumes: operands are valid in the cycle that start is high.
module shift_add_mult #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [WIDTH-1:0]   mcand_i,
    input  logic [WIDTH-1:0]   mplier_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [2*WIDTH-1:0] product_o
);
    logic load;
    logic step;

    shift_add_seq #(.WIDTH(WIDTH)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    shift_add_dp #(.WIDTH(WIDTH)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (step),
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .acc_o    (product_o)
    );

    // R5
    // done_idle_chk: done and busy are never high together.
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));
endmodule

// File: tb/shift_add_mult_test.sv
module shift_add_mult_test;
    localparam int W = 6;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [W-1:0]  mcand_i = '0;
    logic [W-1:0]  mplier_i = '0;
    logic          busy_o;
    logic          done_o;
    logic [PW-1:0] product_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    shift_add_mult #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .mcand_i(mcand_i), .mplier_i(mplier_i),
        .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
    );

    task automatic check(input bit ok, input string req, input logic [PW-1:0] act,
                         input logic [PW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue a request at a negedge; return after the cycle in which done is seen.
    // If interfere is set, send a different start on the second busy cycle.
    task automatic run_mult(input logic [W-1:0] a, input logic [W-1:0] b,
                            input bit interfere, input bit verbose);
        int n;
        logic [PW-1:0] exp;
        exp = PW'(a) * PW'(b);
        mcand_i = a; mplier_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (verbose) begin
            // R2: after the capture edge, busy is high, high half zero, low half = multiplier
            check(busy_o === 1'b1, "R2 busy", PW'(busy_o), 1);
            check(product_o === {{W{1'b0}}, b}, "R2 load", product_o, {{W{1'b0}}, b});
        end
        n = 0;
        while (done_o !== 1'b1 && n < 4 * W) begin
            if (interfere && n == 1) begin
                mcand_i = ~a; mplier_i = ~b; start_i = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
            n++;
            if (verbose && n == 1) begin
                // R3: first iteration, computed from bit 0 of the multiplier
                logic [PW-1:0] s1;
                s1 = ({{W{1'b0}}, b} + (b[0] ? (PW'(a) << W) : '0)) >> 1;
                check(product_o === s1, "R3 step", product_o, s1);
            end
        end
        // R4: done and the fall of busy come W cycles after the capture edge
        check(n == W && busy_o === 1'b0, "R4 latency", PW'(n), PW'(W));
        // R6: unsigned product
        check(product_o === exp, interfere ? "R7 ignored start" : "R6 product", product_o, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [PW-1:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy_o === 1'b0 && done_o === 1'b0, "R1 flags", PW'({busy_o, done_o}), 0);
        check(product_o === '0, "R1 product", product_o, '0);
        rst_n = 1'b1;
        @(negedge clk);

        run_mult(6'd5, 6'd3, 1'b0, 1'b1);
        run_mult(6'd63, 6'd62, 1'b0, 1'b1);
        @(negedge clk);
        // R5: done lasted only one cycle
        check(done_o === 1'b0, "R5 pulse", PW'(done_o), 0);

        // R6: corner values
        run_mult(6'd63, 6'd63, 1'b0, 1'b0);
        run_mult(6'd0, 6'd63, 1'b0, 1'b0);
        run_mult(6'd63, 6'd0, 1'b0, 1'b0);

        // R7: start while busy is ignored
        run_mult(6'd45, 6'd27, 1'b1, 1'b0);

        // R8: the product holds with idle inputs changing
        held = product_o;
        mcand_i = 6'd1; mplier_i = 6'd1;
        repeat (5) @(negedge clk);
        check(product_o === held && busy_o === 1'b0, "R8 hold", product_o, held);

        // R8: start in the done cycle is accepted
        run_mult(6'd9, 6'd7, 1'b0, 1'b0);
        run_mult(6'd11, 6'd13, 1'b0, 1'b1);

        // R6: exhaustive sweep, back to back from the done cycle
        for (int i = 0; i < (1 << W); i++) begin
            for (int j = 0; j < (1 << W); j++) begin
                run_mult(W'(i), W'(j), 1'b0, 1'b0);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule